// File: doc/BRIEF.md
# Serial audio bit and word clock generator

This block turns a master audio clock into the timing a serial DAC link needs. While enabled, the master clock is passed straight through as the converter's system clock. It is also divided down into a bit clock and a left/right word-select clock. The divide ratio follows two settings. One says whether the master clock runs at 256 or 384 times the sample rate. The other says whether each channel slot is 16 or 32 bit clocks long. As a result, one left-plus-right frame always lasts exactly one sample period.

A serializer placed next to this block uses two single-cycle strobes: one at the start of every bit slot and one at the start of every channel slot. The bit and word clocks run only while the block is enabled and sample data is available. When either condition goes away, the frame in progress is completed and the link then parks. Settings are taken up only at frame boundaries, so a frame never mixes two configurations.

Top module: `audio_serclk_gen`

## Requirements
- R1: `sys_clk` equals `mclk` while `enable` is 1 and is held at 0 while `enable` is 0.
- R2: While running, one bit clock period lasts 4 `mclk` cycles for `rate_384`=0 with `slot_32`=1, 8 cycles for `rate_384`=0 with `slot_32`=0, 6 cycles for `rate_384`=1 with `slot_32`=1, and 12 cycles for `rate_384`=1 with `slot_32`=0. `bclk` is low for the first half of each period and high for the second half.
- R3: Each channel slot lasts 32 bit periods when `slot_32`=1 and 16 when `slot_32`=0. A frame is a left slot followed by a right slot.
- R4: `ws` changes only in the cycle in which `bclk` falls, or while the link is idle.
- R5: With `left_high`=0 the left slot is sent with `ws` low and the right slot with `ws` high. With `left_high`=1 both levels are inverted. When idle, `ws` rests at the left level.
- R6: `bit_strobe` is high for exactly the first `mclk` cycle of every bit period. `slot_strobe` is high only in the first cycle of the first bit of each channel slot.
- R7: While `enable` and `data_avail` are not both 1, an idle link stays idle with `bclk` low and no strobes. In the first cycle after an edge that samples both inputs high, a frame starts with both strobes high and the left slot.
- R8: If `enable` or `data_avail` is 0 at the last `mclk` cycle of a frame, the frame still completes. After that, `bclk` stays low, `ws` sits at the left level and no strobes are produced. If both are 1, the next frame follows with no gap.
- R9: Changes to `rate_384`, `slot_32` or `left_high` made during a frame do not affect that frame. They take effect from the next frame.
- R10: After reset, `bclk`, `ws`, `bit_strobe` and `slot_strobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock, 256 or 384 times the sample rate |
| rst_n | input | 1 | Active-low reset, synchronous to `mclk` |
| enable | input | 1 | Turns the interface on |
| rate_384 | input | 1 | 0: master clock is 256 fs, 1: 384 fs |
| slot_32 | input | 1 | 0: 16 bits per channel, 1: 32 bits per channel |
| left_high | input | 1 | 0: left channel while `ws` is low, 1: while `ws` is high |
| data_avail | input | 1 | Sample data is waiting at the converter input |
| sys_clk | output | 1 | Gated copy of `mclk` for the DAC |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word-select (channel) clock |
| bit_strobe | output | 1 | One-cycle pulse at the start of each bit period |
| slot_strobe | output | 1 | One-cycle pulse at the start of each channel slot |

## Verification
Every combination of rate and slot width is exercised over whole frames, cycle by cycle. A wrong divisor shows up as a bit clock edge or strobe in the wrong cycle. A wrong slot length shows up as `ws` flipping early or late. Data and enable are dropped in the middle of a frame to confirm that the frame is completed rather than cut short, and that the link then parks with `bclk` low at the left level. The settings are also changed in the middle of a frame. A design that picked them up at once would stretch the bit clock or flip `ws` inside that frame.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

   typedef struct packed {
      logic rate_hi;    // master clock is the higher multiple of fs
      logic wide;       // wide channel slot
      logic left_high;  // left channel sent while ws is high
   } aclk_cfg_t;

endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half,
   output logic             at_start,
   output logic             wrap,
   output logic             phase_hi
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last     = (half << 1) - CNT_W'(1);
   assign at_start = (cnt == '0);
   assign wrap     = (cnt == last);
   assign phase_hi = (cnt >= half);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/aclk_slot_seq.sv
module aclk_slot_seq #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [IDX_W-1:0] slot_len,
   output logic             frame_last,
   output logic             right_chan,
   output logic             chan_start
);

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;

   assign last_idx   = (slot_len << 1) - IDX_W'(1);
   assign frame_last = (idx == last_idx);
   assign right_chan = (idx >= slot_len);
   assign chan_start = (idx == '0) || (idx == slot_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (!run) begin
         idx <= '0;
      end else if (step) begin
         idx <= frame_last ? '0 : idx + IDX_W'(1);
      end
   end

endmodule

// File: rtl/audio_serclk_gen.sv
module audio_serclk_gen
   import aclk_pkg::*;
#(
   parameter int FS_LO       = 256,
   parameter int FS_HI       = 384,
   parameter int SLOT_NARROW = 16,
   parameter int SLOT_WIDE   = 32
) (
   input  logic mclk,
   input  logic rst_n,
   input  logic enable,
   input  logic rate_384,
   input  logic slot_32,
   input  logic left_high,
   input  logic data_avail,
   output logic sys_clk,
   output logic bclk,
   output logic ws,
   output logic bit_strobe,
   output logic slot_strobe
);

   localparam int HALF_LO  = FS_LO / (4 * SLOT_WIDE);
   localparam int HALF_HI  = FS_HI / (4 * SLOT_WIDE);
   localparam int RATIO    = SLOT_WIDE / SLOT_NARROW;
   localparam int HALF_MAX = HALF_HI * RATIO;
   localparam int CNT_W    = $clog2(2 * HALF_MAX);
   localparam int IDX_W    = $clog2(2 * SLOT_WIDE);

   generate
      if (FS_LO % (4 * SLOT_WIDE) != 0 || FS_HI % (4 * SLOT_WIDE) != 0) begin : g_bad_fs
         $error("fs multiples must divide evenly into wide slots");
      end
      if (SLOT_WIDE <= SLOT_NARROW || SLOT_WIDE % SLOT_NARROW != 0) begin : g_bad_slot
         $error("wide slot must be a multiple of the narrow slot");
      end
      if (FS_HI <= FS_LO) begin : g_bad_order
         $error("higher fs multiple must exceed the lower one");
      end
   endgenerate

   aclk_cfg_t        cfg_in, cfg_q;
   logic             running;
   logic             go;
   logic             fr_end;
   logic [CNT_W-1:0] half;
   logic [IDX_W-1:0] slot_len;
   logic             at_start, wrap, phase_hi;
   logic             frame_last, right_chan, chan_start;

   assign cfg_in = '{rate_hi: rate_384, wide: slot_32, left_high: left_high};
   assign go     = enable & data_avail;
   assign fr_end = running & wrap & frame_last;

   always_comb begin
      int base;
      base     = cfg_q.rate_hi ? HALF_HI : HALF_LO;
      half     = cfg_q.wide ? CNT_W'(base) : CNT_W'(base * RATIO);
      slot_len = cfg_q.wide ? IDX_W'(SLOT_WIDE) : IDX_W'(SLOT_NARROW);
   end

   // Settings are taken while idle and at each frame boundary only.
   always_ff @(posedge mclk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cfg_q   <= '0;
      end else if (!running || fr_end) begin
         running <= go;
         cfg_q   <= cfg_in;
      end
   end

   aclk_bit_div #(.CNT_W(CNT_W)) div_i (
      .clk      (mclk),
      .rst_n    (rst_n),
      .run      (running),
      .half     (half),
      .at_start (at_start),
      .wrap     (wrap),
      .phase_hi (phase_hi)
   );

   aclk_slot_seq #(.IDX_W(IDX_W)) seq_i (
      .clk        (mclk),
      .rst_n      (rst_n),
      .run        (running),
      .step       (wrap),
      .slot_len   (slot_len),
      .frame_last (frame_last),
      .right_chan (right_chan),
      .chan_start (chan_start)
   );

   assign sys_clk     = mclk & enable;
   assign bclk        = running & phase_hi;
   assign ws          = cfg_q.left_high ^ right_chan;
   assign bit_strobe  = running & at_start;
   assign slot_strobe = bit_strobe & chan_start;

endmodule

// File: rtl/aclk_checker.sv
module aclk_checker (
   input logic clk,
   input logic rst_n,
   input logic bclk,
   input logic ws,
   input logic bit_strobe,
   input logic slot_strobe
);

   assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(ws) && $past(bclk)) |-> !bclk);

   assert_slot_in_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_strobe |-> bit_strobe);

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> !bit_strobe);

   assert_strobe_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> !bclk);

   assert_rise_not_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk) |-> !bit_strobe);

endmodule

bind audio_serclk_gen aclk_checker chk_i (
   .clk         (mclk),
   .rst_n       (rst_n),
   .bclk        (bclk),
   .ws          (ws),
   .bit_strobe  (bit_strobe),
   .slot_strobe (slot_strobe)
);

// File: tb/audio_serclk_gen_tb_top.sv
module audio_serclk_gen_tb_top;

   logic mclk = 1'b0;
   logic rst_n, enable, rate_384, slot_32, left_high, data_avail;
   logic sys_clk, bclk, ws, bit_strobe, slot_strobe;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #5 mclk = ~mclk;

   audio_serclk_gen dut_i (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .enable      (enable),
      .rate_384    (rate_384),
      .slot_32     (slot_32),
      .left_high   (left_high),
      .data_avail  (data_avail),
      .sys_clk     (sys_clk),
      .bclk        (bclk),
      .ws          (ws),
      .bit_strobe  (bit_strobe),
      .slot_strobe (slot_strobe)
   );

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s {bclk,ws,bit,slot} actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic expect_idle(input int n, input logic pol, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge mclk);
         chk(tag, {bclk, ws, bit_strobe, slot_strobe}, {1'b0, pol, 1'b0, 1'b0});
      end
   endtask

   // Called at the negedge showing cycle 0 of a frame; ends on its last cycle.
   task automatic check_frame(input bit r, input bit s, input bit p,
                              input bit nr, input bit ns, input bit np,
                              input bit drop_data, input bit drop_en, input string tag);
      int slot = s ? 32 : 16;
      int hp   = (r ? 3 : 2) * (s ? 1 : 2);
      for (int b = 0; b < 2 * slot; b++) begin
         for (int j = 0; j < 2 * hp; j++) begin
            if (b != 0 || j != 0) @(negedge mclk);
            chk(tag, {bclk, ws, bit_strobe, slot_strobe},
                {logic'(j >= hp), logic'(p ^ (b >= slot)), logic'(j == 0),
                 logic'(j == 0 && (b == 0 || b == slot))});
            if (b == 2 && j == 0) begin
               rate_384  = nr;
               slot_32   = ns;
               left_high = np;
               if (drop_data) data_avail = 1'b0;
               if (drop_en)   enable     = 1'b0;
            end
         end
      end
   endtask

   task automatic start_link(input bit r, input bit s, input bit p);
      rate_384 = r; slot_32 = s; left_high = p;
      enable = 1'b1; data_avail = 1'b1;
      @(negedge mclk);
   endtask

   task automatic t_reset;
      chk("R10 reset", {bclk, ws, bit_strobe, slot_strobe}, 4'b0000);
   endtask

   task automatic t_sysclk;
      enable = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(posedge mclk); #1;
         chk("R1 forward high", {3'b000, sys_clk}, 4'b0001);
         @(negedge mclk); #1;
         chk("R1 forward low", {3'b000, sys_clk}, 4'b0000);
      end
      enable = 1'b0;
      @(posedge mclk); #1;
      chk("R1 gated", {3'b000, sys_clk}, 4'b0000);
      @(negedge mclk);
   endtask

   task automatic t_no_data;
      enable = 1'b1; data_avail = 1'b0; left_high = 1'b0;
      expect_idle(24, 1'b0, "R7 no data");
      enable = 1'b0; data_avail = 1'b1;
      expect_idle(8, 1'b0, "R7 disabled");
   endtask

   task automatic t_modes;
      for (int m = 0; m < 4; m++) begin
         bit r = m[1];
         bit s = m[0];
         bit p = r ^ s;
         start_link(r, s, p);
         check_frame(r, s, p, r, s, p, 1'b0, 1'b0, "R2/R3/R5/R6/R7 frame");
         @(negedge mclk);
         check_frame(r, s, p, r, s, p, 1'b1, 1'b0, "R3/R8 back-to-back");
         expect_idle(16, p, "R8 parked after data drop");
      end
   endtask

   task automatic t_cfg_midframe;
      start_link(1'b0, 1'b1, 1'b0);
      check_frame(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 old settings kept");
      @(negedge mclk);
      check_frame(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 new settings");
      expect_idle(10, 1'b1, "R9 idle level");
   endtask

   task automatic t_enable_drop;
      start_link(1'b1, 1'b1, 1'b1);
      check_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R8 enable drop frame");
      expect_idle(12, 1'b1, "R8 parked after enable drop");
   endtask

   initial begin
      rst_n = 1'b0; enable = 1'b0; rate_384 = 1'b0; slot_32 = 1'b0;
      left_high = 1'b0; data_avail = 1'b0;
      repeat (3) @(posedge mclk);
      @(negedge mclk);
      rst_n = 1'b1;
      t_reset();
      t_sysclk();
      t_no_data();
      t_modes();
      t_cfg_midframe();
      t_enable_drop();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge mclk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule